// File: doc/BRIEF.md
# NAND Erase Command and Status Unit

This unit sits on the device side of a small byte-wide NAND-style memory port. The host writes command bytes, address bytes and read requests through three synchronous qualifiers that share one data bus. The unit decodes a two-step block erase: a setup opcode, then exactly two address bytes, then a confirm opcode. Only after that full sequence does it start a modelled erase. While the erase runs, the unit lowers its ready output for a fixed number of clock cycles. When the erase ends, it records the pass or fail result.

A status opcode moves the unit into a status-read mode. The mode stays set until the host writes some other command. In this mode, holding the read qualifier high puts a status byte on the output bus. That byte follows the live busy, fail and protect state, so the host does not need a new strobe to see a change. A write-protect input blocks an erase at the confirm step and reports the block as a failure. The array, program and page-read paths are not part of this unit.

Top module: `nand_cmd_status`

## Requirements
- R1: After reset, `rdy` is 1, `status_mode` is 0, `erase_go` is 0, and `dout` is 0 even with `read_strobe` high.
- R2: The sequence command 60h, two address bytes, then command D0h with `wp_n` = 1 raises `erase_go` for exactly one cycle. This happens in the cycle after D0h is accepted. The first address byte is the low byte of a 16-bit row address and the second byte is the high byte.
- R3: D0h does not start an erase in any of these cases: no preceding 60h, only one address byte, or three address bytes. In each case `rdy` stays 1 and `erase_go` stays 0.
- R4: `rdy` is 0 for exactly ERASE_CYC clock cycles. The busy period starts in the cycle after D0h is accepted.
- R5: Command 70h sets status-read mode. While `read_strobe` is held high, `dout` follows the live status byte without any new strobe. 70h is accepted even while busy.
- R6: Status-read mode persists across reads until another command is accepted. 00h, 50h or any other opcode clears it. Outside status mode, or with `read_strobe` low, `dout` is 0.
- R7: The status byte layout is: bit 0 is the fail flag (1 = last erase failed), bit 6 is 1 when ready and 0 when busy, and bit 7 is 1 when not protected (the `wp_n` level). Bits 1 to 5 are 0.
- R8: `erase_fail` is sampled on the last busy cycle and stored as the fail flag. Starting a new erase clears the fail flag.
- R9: If `wp_n` is 0 when a valid D0h arrives, no erase starts, `rdy` stays 1, and the fail flag is set.
- R10: While busy, every command other than 70h is ignored, and so are address bytes. An ignored 00h leaves status mode set, and an ignored 60h leaves no erase setup pending afterwards.
- R11: `erase_blk` is the row address with its low OFS_BITS bits dropped (default 4). Address bits inside a block do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | `din` carries a command byte this cycle |
| addr_valid | input | 1 | `din` carries an address byte this cycle |
| read_strobe | input | 1 | Host read request; enables `dout` |
| din | input | DATA_W | Command or address byte |
| wp_n | input | 1 | 0 = write protected |
| erase_fail | input | 1 | Erase outcome, sampled on the last busy cycle |
| dout | output | DATA_W | Status byte while reading in status mode, otherwise 0 |
| rdy | output | 1 | 1 = ready, 0 = erase in progress |
| status_mode | output | 1 | Status-read mode is active |
| erase_go | output | 1 | One-cycle pulse when an erase starts |
| erase_blk | output | 16-OFS_BITS | Block index of the current erase |

## Verification
The assertions assume that `cmd_valid` and `addr_valid` are never high in the same cycle. They also assume that `erase_fail` and `wp_n` only change while the unit is quiet, not in the middle of a transaction. The stimulus drives each command or address as a single one-cycle qualifier at a falling edge and never overlaps the two. It changes the fail and protect inputs only between sequences. The output checks sample half a cycle after each clock edge.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
   localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
   localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
   localparam logic [7:0] OP_STATUS      = 8'h70;
   localparam logic [7:0] OP_READ_A      = 8'h00;
   localparam logic [7:0] OP_READ_B      = 8'h50;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SETUP = 2'd1,
      SEQ_ONE   = 2'd2,
      SEQ_TWO   = 2'd3
   } seq_state_t;
endpackage

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nand_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic                addr_valid,
   input  logic [DATA_W-1:0]   din,
   input  logic                busy,
   input  logic                wp_n,
   output logic                start_req,
   output logic                prot_hit,
   output logic                status_mode,
   output logic [2*DATA_W-1:0] row_addr
);
   localparam int ROW_W = 2 * DATA_W;

   seq_state_t st_q, st_d;
   logic [7:0] op;
   logic cmd_ok, addr_ok, confirm;

   assign op      = din[7:0];
   assign cmd_ok  = cmd_valid && (!busy || op == OP_STATUS);
   assign addr_ok = addr_valid && !busy;
   assign confirm = cmd_ok && op == OP_ERASE_GO && st_q == SEQ_TWO;
   assign start_req = confirm && wp_n;
   assign prot_hit  = confirm && !wp_n;

   always_comb begin
      st_d = st_q;
      if (cmd_ok) begin
         if (op == OP_ERASE_SETUP)  st_d = SEQ_SETUP;
         else if (op != OP_STATUS)  st_d = SEQ_IDLE;
      end else if (addr_ok) begin
         case (st_q)
            SEQ_SETUP: st_d = SEQ_ONE;
            SEQ_ONE:   st_d = SEQ_TWO;
            default:   st_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= SEQ_IDLE;
         status_mode <= 1'b0;
         row_addr    <= '0;
      end else begin
         st_q <= st_d;
         if (cmd_ok) status_mode <= (op == OP_STATUS);
         if (addr_ok && st_q == SEQ_SETUP) row_addr[DATA_W-1:0] <= din;
         if (addr_ok && st_q == SEQ_ONE)   row_addr[ROW_W-1:DATA_W] <= din;
      end
   end

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_valid && op != OP_STATUS |=> st_q == $past(st_q));
   // R3
   confirm_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> st_q == SEQ_TWO);
endmodule

// File: rtl/nand_erase_timer.sv
module nand_erase_timer #(
   parameter int ERASE_CYC = 40,
   parameter int BLK_W     = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             prot_hit,
   input  logic             erase_fail,
   input  logic [BLK_W-1:0] blk_in,
   output logic             busy,
   output logic             fail,
   output logic             go_pulse,
   output logic [BLK_W-1:0] blk_out
);
   localparam int CNT_W = $clog2(ERASE_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ERASE_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         fail     <= 1'b0;
         go_pulse <= 1'b0;
         cnt      <= '0;
         blk_out  <= '0;
      end else begin
         go_pulse <= start_req;
         if (start_req) begin
            busy    <= 1'b1;
            fail    <= 1'b0;
            cnt     <= CNT_LAST;
            blk_out <= blk_in;
         end else if (prot_hit) begin
            fail <= 1'b1;
         end else if (busy) begin
            if (cnt == '0) begin
               busy <= 1'b0;
               fail <= erase_fail;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R10
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> !busy);
   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt != '0 |=> busy);
   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_LAST);
endmodule

// File: rtl/nand_status_mux.sv
module nand_status_mux #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              status_mode,
   input  logic              read_strobe,
   input  logic              busy,
   input  logic              fail,
   input  logic              wp_n,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] stat_byte, sel;

   always_comb begin
      stat_byte    = '0;
      stat_byte[0] = fail;
      stat_byte[6] = !busy;
      stat_byte[7] = wp_n;
      sel = (status_mode && read_strobe) ? stat_byte : '0;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= '0;
            else        dout <= sel;
         end
      end else begin : g_comb
         assign dout = sel;
         // R7
         ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status_mode && read_strobe |-> dout[6] == !busy && dout[5:1] == '0);
         // R6
         quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(status_mode && read_strobe) |-> dout == '0);
      end
   endgenerate
endmodule

// File: rtl/nand_cmd_status.sv
module nand_cmd_status #(
   parameter int DATA_W    = 8,
   parameter int OFS_BITS  = 4,
   parameter int ERASE_CYC = 40,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic                         addr_valid,
   input  logic                         read_strobe,
   input  logic [DATA_W-1:0]            din,
   input  logic                         wp_n,
   input  logic                         erase_fail,
   output logic [DATA_W-1:0]            dout,
   output logic                         rdy,
   output logic                         status_mode,
   output logic                         erase_go,
   output logic [2*DATA_W-OFS_BITS-1:0] erase_blk
);
   localparam int ROW_W = 2 * DATA_W;
   localparam int BLK_W = ROW_W - OFS_BITS;

   generate
      if (DATA_W < 8)              begin : g_bad_w   $error("DATA_W must be at least 8"); end
      if (OFS_BITS >= ROW_W)       begin : g_bad_ofs $error("OFS_BITS too large"); end
      if (ERASE_CYC < 2)           begin : g_bad_cyc $error("ERASE_CYC must be at least 2"); end
   endgenerate

   logic start_req, prot_hit, busy, fail;
   logic [ROW_W-1:0] row_addr;

   nand_cmd_seq #(.DATA_W(DATA_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .addr_valid(addr_valid),
      .din(din), .busy(busy), .wp_n(wp_n), .start_req(start_req),
      .prot_hit(prot_hit), .status_mode(status_mode), .row_addr(row_addr));

   nand_erase_timer #(.ERASE_CYC(ERASE_CYC), .BLK_W(BLK_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .prot_hit(prot_hit),
      .erase_fail(erase_fail), .blk_in(row_addr[ROW_W-1:OFS_BITS]),
      .busy(busy), .fail(fail), .go_pulse(erase_go), .blk_out(erase_blk));

   nand_status_mux #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) mux_i (
      .clk(clk), .rst_n(rst_n), .status_mode(status_mode),
      .read_strobe(read_strobe), .busy(busy), .fail(fail), .wp_n(wp_n),
      .dout(dout));

   assign rdy = !busy;

   // R2
   go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> !erase_go);
   // R9
   prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n && !busy |=> !erase_go);
   // R4
   go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> !rdy);
endmodule

// File: tb/nand_cmd_status_tb.sv
module nand_cmd_status_tb_top;
   localparam int E = 40;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 0, addr_valid = 0, read_strobe = 0, wp_n = 1, erase_fail = 0;
   logic [7:0] din = 0, dout;
   logic rdy, status_mode, erase_go;
   logic [11:0] erase_blk;
   int tests = 0, fails = 0, cyc = 0;
   logic [7:0] exp_b;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   nand_cmd_status #(.ERASE_CYC(E)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .addr_valid(addr_valid),
      .read_strobe(read_strobe), .din(din), .wp_n(wp_n), .erase_fail(erase_fail),
      .dout(dout), .rdy(rdy), .status_mode(status_mode), .erase_go(erase_go),
      .erase_blk(erase_blk));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_cmd(input logic [7:0] b);
      @(negedge clk); din = b; cmd_valid = 1;
      @(negedge clk); cmd_valid = 0;
   endtask

   task automatic send_addr(input logic [7:0] b);
      @(negedge clk); din = b; addr_valid = 1;
      @(negedge clk); addr_valid = 0;
   endtask

   task automatic read_chk(input string req, input logic [7:0] exp);
      @(negedge clk); read_strobe = 1; #2;
      check(req, dout, exp);
      read_strobe = 0;
   endtask

   task automatic wait_ready();
      while (!rdy) @(negedge clk);
   endtask

   // op: 0 command, 1 address, 2 status read check; then byte, then expected dout
   localparam logic [17:0] VEC [12] = '{
      {2'd0, 8'h70, 8'h00}, {2'd2, 8'h00, 8'hC0}, {2'd2, 8'h00, 8'hC0},
      {2'd0, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h00}, {2'd0, 8'h70, 8'h00},
      {2'd2, 8'h00, 8'hC0}, {2'd0, 8'h50, 8'h00}, {2'd2, 8'h00, 8'h00},
      {2'd0, 8'h70, 8'h00}, {2'd0, 8'h90, 8'h00}, {2'd2, 8'h00, 8'h00}};

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      @(negedge clk); read_strobe = 1; #2;
      check("R1 rdy", rdy, 1); check("R1 mode", status_mode, 0);
      check("R1 go", erase_go, 0); check("R1 dout", dout, 0);
      read_strobe = 0;

      // R5 R6 R7 table walk
      foreach (VEC[i]) begin
         case (VEC[i][17:16])
            2'd0: send_cmd(VEC[i][15:8]);
            2'd1: send_addr(VEC[i][15:8]);
            default: read_chk("R6/R7 table", VEC[i][7:0]);
         endcase
      end

      // R3 D0h out of context
      send_cmd(8'hD0);
      check("R3 lone confirm", {rdy, erase_go}, 2'b10);
      send_cmd(8'h60); send_addr(8'h11); send_cmd(8'hD0);
      check("R3 one addr", {rdy, erase_go}, 2'b10);
      send_cmd(8'h60); send_addr(8'h11); send_addr(8'h22); send_addr(8'h33); send_cmd(8'hD0);
      check("R3 three addr", {rdy, erase_go}, 2'b10);

      // R2 R4 R5 R10 R11 full erase
      send_cmd(8'h60); send_addr(8'h3A); send_addr(8'h5C); send_cmd(8'hD0);
      t0 = cyc;
      check("R2 go pulse", erase_go, 1); check("R11 block", erase_blk, 12'h5C3);
      check("R4 busy", rdy, 0);
      @(negedge clk); check("R2 single pulse", erase_go, 0);
      send_cmd(8'h70);
      read_strobe = 1; #2; check("R5 busy status", dout, 8'h80);
      send_cmd(8'h00); #2; check("R10 mode kept", dout, 8'h80);
      send_cmd(8'h60); send_addr(8'h01); send_addr(8'h02);
      wait_ready();
      check("R4 busy length", cyc - t0, E);
      #2; check("R5 live update", dout, 8'hC0);
      read_strobe = 0;
      send_cmd(8'hD0);
      check("R10 no stale setup", {rdy, erase_go}, 2'b10);

      // R8 fail sampling and clearing
      erase_fail = 1;
      send_cmd(8'h60); send_addr(8'h35); send_addr(8'h5C); send_cmd(8'hD0);
      check("R11 offset ignored", erase_blk, 12'h5C3);
      wait_ready(); erase_fail = 0;
      send_cmd(8'h70); read_chk("R8 fail set", 8'hC1);
      send_cmd(8'h60); send_addr(8'h40); send_addr(8'h12); send_cmd(8'hD0);
      check("R11 other block", erase_blk, 12'h124);
      send_cmd(8'h70); read_chk("R8 fail cleared", 8'h80);
      wait_ready();

      // R9 write protect
      wp_n = 0;
      send_cmd(8'h60); send_addr(8'h00); send_addr(8'h77); send_cmd(8'hD0);
      check("R9 no erase", {rdy, erase_go}, 2'b10);
      send_cmd(8'h70); read_chk("R9 protect status", 8'h41);
      wp_n = 1;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule